// File: doc/BRIEF.md
# Trimmed temperature code converter

This block translates between a temperature in degrees Celsius and the raw code a thermal sensor produces, in either direction. It corrects for each part's own sensor offset and slope using two factory trim bytes. The trim bytes are taken from a fused trim word and checked on every cycle. A trim byte that is blank, or that lies outside a programmable window, is replaced by the matching byte of a fallback word.

A caller places the operands on the inputs and pulses `in_valid`. One clock later the converted value appears on `out_value` with `out_valid` high. The error flag is returned with it.

The calibration selector picks the conversion:
- a two-point linear fit;
- a one-point offset, used for either reference temperature;
- a fixed default offset.

A separate pass-through input bypasses all of these and returns the input unchanged. An optional legacy range check rejects inputs that lie outside a fixed window.

Top module: `thermo_code_conv`

## Requirements
- R1: When `hw_pass` is 1, the result equals the zero-extended input and `out_err` is 0, in both directions. The legacy range check does not apply in this case.
- R2: Calibration code 3 (two-point) with `to_temp`=0 gives code = (T − T1)·(E2 − E1)/(T2 − T1) + E1.
- R3: Calibration code 3 with `to_temp`=1 gives temperature = (C − E1)·(T2 − T1)/(E2 − E1) + T1.
- R4: Calibration codes 1 and 2 (one-point) give code = T + E1 − T1, and temperature = C − E1 + T1 in reverse.
- R5: Calibration code 0 (none) gives code = T + ofs, and temperature = C − ofs. The offset `def_ofs` is a signed value.
- R6: E1 is bits [7:0] of `trim_word`. It is replaced by bits [7:0] of `fuse_word` when it is zero, below `trim_min`, or above `trim_max`. Both bounds are inclusive.
- R7: E2 is the byte of `trim_word` starting at bit E2_SHIFT, with a default of 8. It is replaced by the same byte of `fuse_word` only when it is zero.
- R8: With `legacy_chk`=1 the error flag is raised in two cases: a temperature input outside 25..125, or a code input outside 75..175. Both ranges are inclusive. Whenever the error flag is raised, the value output is 0.
- R9: In two-point mode, a zero divisor raises the error flag. The divisor is T2 − T1 in the forward direction and E2 − E1 in reverse.
- R10: Division is signed and truncates toward zero. For example, −30/60 gives 0, and −75/30 gives −2.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Without a strobe, `out_value` and `out_err` hold their last values.
- R12: Synchronous reset clears `out_valid`, `out_value` and `out_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: convert the present operands |
| to_temp | input | 1 | 0 = temperature to code, 1 = code to temperature |
| hw_pass | input | 1 | Pass the input through unchanged |
| cal_mode | input | 2 | 0 none, 1 one-point at 25 °C, 2 one-point at 85 °C, 3 two-point |
| legacy_chk | input | 1 | Enable the fixed input range check |
| din | input | VW | Temperature or code to convert (unsigned) |
| trim_word | input | TW | Fused trim word holding E1 and E2 |
| fuse_word | input | TW | Fallback word for substituted trim bytes |
| trim_min | input | VW | Lowest accepted E1 |
| trim_max | input | VW | Highest accepted E1 |
| ref_t1 | input | VW | First reference temperature T1 |
| ref_t2 | input | VW | Second reference temperature T2 |
| def_ofs | input | VW | Signed default offset |
| out_valid | output | 1 | Result valid |
| out_value | output | 2·VW+4 | Signed converted value |
| out_err | output | 1 | Range or divisor error |

## Verification
All operand handling is combinational. Only one register stage stands between a strobe and its result, so every result, error flag and valid pulse is due on the first rising edge after the strobe.

The bench drives operands and the strobe on a falling edge. It drops the strobe on the next falling edge and samples the outputs at that moment, exactly one rising edge later.

The hold and idle checks sample one further falling edge on, after an edge with no strobe. The reset checks sample after the reset edge.

// File: rtl/thermo_pkg.sv
`timescale 1ns/1ps
package thermo_pkg;
  // calibration selector; values match the hardware field encoding
  typedef enum logic [1:0] {
    CAL_NONE   = 2'd0,
    CAL_ONE_25 = 2'd1,
    CAL_ONE_85 = 2'd2,
    CAL_TWO    = 2'd3
  } cal_e;
endpackage

// File: rtl/trim_select.sv
`timescale 1ns/1ps
module trim_select #(
  parameter int VW       = 8,
  parameter int TW       = 16,
  parameter int E2_SHIFT = 8
) (
  input  logic [TW-1:0] trim_word,
  input  logic [TW-1:0] fuse_word,
  input  logic [VW-1:0] lim_lo,
  input  logic [VW-1:0] lim_hi,
  output logic [VW-1:0] e1,
  output logic [VW-1:0] e2
);
  logic [VW-1:0] e1_raw, e2_raw;
  logic          e1_bad;

  always_comb begin
    e1_raw = trim_word[VW-1:0];
    e2_raw = trim_word[E2_SHIFT +: VW];
    e1_bad = (e1_raw == '0) || (e1_raw < lim_lo) || (e1_raw > lim_hi);
    e1     = e1_bad ? fuse_word[VW-1:0] : e1_raw;
    e2     = (e2_raw == '0) ? fuse_word[E2_SHIFT +: VW] : e2_raw;
  end
endmodule

// File: rtl/range_guard.sv
`timescale 1ns/1ps
module range_guard #(
  parameter int VW   = 8,
  parameter int T_LO = 25,
  parameter int T_HI = 125,
  parameter int C_LO = 75,
  parameter int C_HI = 175
) (
  input  logic          enable,
  input  logic          is_code,
  input  logic [VW-1:0] value,
  output logic          bad
);
  localparam logic [VW-1:0] TLO = VW'(T_LO);
  localparam logic [VW-1:0] THI = VW'(T_HI);
  localparam logic [VW-1:0] CLO = VW'(C_LO);
  localparam logic [VW-1:0] CHI = VW'(C_HI);

  always_comb begin
    if (!enable)      bad = 1'b0;
    else if (is_code) bad = (value < CLO) || (value > CHI);
    else              bad = (value < TLO) || (value > THI);
  end
endmodule

// File: rtl/conv_core.sv
`timescale 1ns/1ps
module conv_core
  import thermo_pkg::*;
#(
  parameter int VW = 8,
  parameter int IW = 2*VW+4
) (
  input  logic                 to_temp,
  input  cal_e                 mode,
  input  logic [VW-1:0]        din,
  input  logic [VW-1:0]        e1,
  input  logic [VW-1:0]        e2,
  input  logic [VW-1:0]        t1,
  input  logic [VW-1:0]        t2,
  input  logic signed [VW-1:0] ofs,
  output logic signed [IW-1:0] result,
  output logic                 div_zero
);
  localparam int PAD = IW - VW;
  localparam logic signed [IW-1:0] ONE = {{(IW-1){1'b0}}, 1'b1};

  logic signed [IW-1:0] x, se1, se2, st1, st2, sofs;
  logic signed [IW-1:0] num, den, den_safe, quo;

  always_comb begin
    x    = $signed({{PAD{1'b0}}, din});
    se1  = $signed({{PAD{1'b0}}, e1});
    se2  = $signed({{PAD{1'b0}}, e2});
    st1  = $signed({{PAD{1'b0}}, t1});
    st2  = $signed({{PAD{1'b0}}, t2});
    sofs = {{PAD{ofs[VW-1]}}, ofs};

    if (!to_temp) begin
      num = (x - st1) * (se2 - se1);
      den = st2 - st1;
    end else begin
      num = (x - se1) * (st2 - st1);
      den = se2 - se1;
    end
    den_safe = (den == '0) ? ONE : den;
    quo      = num / den_safe;   // signed: truncates toward zero

    div_zero = 1'b0;
    case (mode)
      CAL_TWO: begin
        result   = quo + (to_temp ? st1 : se1);
        div_zero = (den == '0);
      end
      CAL_ONE_25, CAL_ONE_85:
        result = to_temp ? (x - se1 + st1) : (x + se1 - st1);
      default:
        result = to_temp ? (x - sofs) : (x + sofs);
    endcase
  end
endmodule

// File: rtl/thermo_code_conv.sv
`timescale 1ns/1ps
module thermo_code_conv
  import thermo_pkg::*;
#(
  parameter int VW       = 8,
  parameter int TW       = 16,
  parameter int E2_SHIFT = 8,
  parameter int T_LO     = 25,
  parameter int T_HI     = 125,
  parameter int C_LO     = 75,
  parameter int C_HI     = 175,
  localparam int IW      = 2*VW+4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 to_temp,
  input  logic                 hw_pass,
  input  logic [1:0]           cal_mode,
  input  logic                 legacy_chk,
  input  logic [VW-1:0]        din,
  input  logic [TW-1:0]        trim_word,
  input  logic [TW-1:0]        fuse_word,
  input  logic [VW-1:0]        trim_min,
  input  logic [VW-1:0]        trim_max,
  input  logic [VW-1:0]        ref_t1,
  input  logic [VW-1:0]        ref_t2,
  input  logic signed [VW-1:0] def_ofs,
  output logic                 out_valid,
  output logic signed [IW-1:0] out_value,
  output logic                 out_err
);
  logic [VW-1:0]        e1, e2;
  logic signed [IW-1:0] core_val, nxt_val;
  logic                 div_zero, range_bad, nxt_err;

  trim_select #(.VW(VW), .TW(TW), .E2_SHIFT(E2_SHIFT)) u_trim (
    .trim_word (trim_word),
    .fuse_word (fuse_word),
    .lim_lo    (trim_min),
    .lim_hi    (trim_max),
    .e1        (e1),
    .e2        (e2)
  );

  range_guard #(.VW(VW), .T_LO(T_LO), .T_HI(T_HI), .C_LO(C_LO), .C_HI(C_HI)) u_guard (
    .enable  (legacy_chk),
    .is_code (to_temp),
    .value   (din),
    .bad     (range_bad)
  );

  conv_core #(.VW(VW), .IW(IW)) u_core (
    .to_temp  (to_temp),
    .mode     (cal_e'(cal_mode)),
    .din      (din),
    .e1       (e1),
    .e2       (e2),
    .t1       (ref_t1),
    .t2       (ref_t2),
    .ofs      (def_ofs),
    .result   (core_val),
    .div_zero (div_zero)
  );

  always_comb begin
    if (hw_pass) begin
      nxt_err = 1'b0;
      nxt_val = $signed({{(IW-VW){1'b0}}, din});
    end else begin
      nxt_err = div_zero | range_bad;
      nxt_val = nxt_err ? '0 : core_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_value <= nxt_val;
        out_err   <= nxt_err;
      end
    end
  end

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_value) && $stable(out_err)));

  assert_pass_through_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hw_pass) |=> (!out_err && $unsigned(out_value) == IW'($past(din))));

  assert_div_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hw_pass && cal_mode == 2'd3 && !to_temp && ref_t1 == ref_t2) |=> out_err);

  assert_err_zero_value_R8: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_value == '0));
endmodule

// File: tb/thermo_code_conv_bench.sv
`timescale 1ns/1ps
module thermo_code_conv_bench;
  localparam int VW = 8;
  localparam int TW = 16;
  localparam int IW = 2*VW+4;

  typedef struct packed {
    logic [3:0]    tag;
    logic          dir;
    logic          hw;
    logic [1:0]    mode;
    logic          leg;
    logic [7:0]    din;
    logic [15:0]   trim;
    logic [15:0]   fuse;
    logic [7:0]    t1;
    logic [7:0]    t2;
    logic [7:0]    ofs;
    logic [IW-1:0] eval;
    logic          eerr;
  } vec_t;

  localparam logic [15:0] TRW = 16'h5032;  // E1 = 50, E2 = 80
  localparam logic [15:0] FBW = 16'h4A30;  // fallback E1 = 48, E2 = 74
  localparam logic [7:0]  TA  = 8'd25;
  localparam logic [7:0]  TB  = 8'd85;
  localparam logic [7:0]  OF  = 8'd50;
  localparam int NV = 36;

  localparam vec_t VEC [NV] = '{
    // R1 pass-through, range check ignored
    '{4'd1, 1'b0, 1'b1, 2'd3, 1'b1, 8'd200, TRW, FBW, TA, TB, OF, 20'sd200, 1'b0},
    '{4'd1, 1'b1, 1'b1, 2'd0, 1'b0, 8'd7,   TRW, FBW, TA, TB, OF, 20'sd7,   1'b0},
    '{4'd1, 1'b1, 1'b1, 2'd1, 1'b1, 8'd10,  TRW, FBW, TA, TB, OF, 20'sd10,  1'b0},
    // R2 two-point forward
    '{4'd2, 1'b0, 1'b0, 2'd3, 1'b0, 8'd85,  TRW, FBW, TA, TB, OF, 20'sd80,  1'b0},
    '{4'd2, 1'b0, 1'b0, 2'd3, 1'b0, 8'd55,  TRW, FBW, TA, TB, OF, 20'sd65,  1'b0},
    // R3 two-point reverse
    '{4'd3, 1'b1, 1'b0, 2'd3, 1'b0, 8'd65,  TRW, FBW, TA, TB, OF, 20'sd55,  1'b0},
    '{4'd3, 1'b1, 1'b0, 2'd3, 1'b0, 8'd80,  TRW, FBW, TA, TB, OF, 20'sd85,  1'b0},
    // R10 truncation toward zero
    '{4'd10, 1'b0, 1'b0, 2'd3, 1'b0, 8'd26, TRW, FBW, TA, TB, OF, 20'sd50,  1'b0},
    '{4'd10, 1'b0, 1'b0, 2'd3, 1'b0, 8'd24, TRW, FBW, TA, TB, OF, 20'sd50,  1'b0},
    '{4'd10, 1'b0, 1'b0, 2'd3, 1'b0, 8'd0,  TRW, FBW, TA, TB, OF, 20'sd38,  1'b0},
    '{4'd10, 1'b1, 1'b0, 2'd3, 1'b0, 8'd51, TRW, FBW, TA, 8'd100, OF, 20'sd27, 1'b0},
    '{4'd10, 1'b1, 1'b0, 2'd3, 1'b0, 8'd49, TRW, FBW, TA, 8'd100, OF, 20'sd23, 1'b0},
    // R4 one-point, both selector codes
    '{4'd4, 1'b0, 1'b0, 2'd1, 1'b0, 8'd40,  TRW, FBW, TA, TB, OF, 20'sd65,  1'b0},
    '{4'd4, 1'b1, 1'b0, 2'd2, 1'b0, 8'd65,  TRW, FBW, TA, TB, OF, 20'sd40,  1'b0},
    '{4'd4, 1'b0, 1'b0, 2'd2, 1'b0, 8'd90,  TRW, FBW, TA, TB, OF, 20'sd115, 1'b0},
    // R5 fixed offset
    '{4'd5, 1'b0, 1'b0, 2'd0, 1'b0, 8'd30,  TRW, FBW, TA, TB, OF, 20'sd80,  1'b0},
    '{4'd5, 1'b1, 1'b0, 2'd0, 1'b0, 8'd20,  TRW, FBW, TA, TB, OF, -20'sd30, 1'b0},
    '{4'd5, 1'b0, 1'b0, 2'd0, 1'b0, 8'd30,  TRW, FBW, TA, TB, 8'hF6, 20'sd20, 1'b0},
    // R6 E1 validation (window 40..120)
    '{4'd6, 1'b0, 1'b0, 2'd1, 1'b0, 8'd25,  16'h5000, FBW, TA, TB, OF, 20'sd48,  1'b0},
    '{4'd6, 1'b0, 1'b0, 2'd1, 1'b0, 8'd25,  16'h5020, FBW, TA, TB, OF, 20'sd48,  1'b0},
    '{4'd6, 1'b0, 1'b0, 2'd1, 1'b0, 8'd25,  16'h507F, FBW, TA, TB, OF, 20'sd48,  1'b0},
    '{4'd6, 1'b0, 1'b0, 2'd1, 1'b0, 8'd25,  16'h5078, FBW, TA, TB, OF, 20'sd120, 1'b0},
    '{4'd6, 1'b0, 1'b0, 2'd1, 1'b0, 8'd25,  16'h5028, FBW, TA, TB, OF, 20'sd40,  1'b0},
    // R7 E2 substitution only when zero
    '{4'd7, 1'b0, 1'b0, 2'd3, 1'b0, 8'd85,  16'h0032, FBW, TA, TB, OF, 20'sd74,  1'b0},
    '{4'd7, 1'b0, 1'b0, 2'd3, 1'b0, 8'd85,  16'h0132, FBW, TA, TB, OF, 20'sd1,   1'b0},
    // R8 legacy range check
    '{4'd8, 1'b0, 1'b0, 2'd0, 1'b1, 8'd24,  TRW, FBW, TA, TB, OF, 20'sd0,   1'b1},
    '{4'd8, 1'b0, 1'b0, 2'd0, 1'b1, 8'd25,  TRW, FBW, TA, TB, OF, 20'sd75,  1'b0},
    '{4'd8, 1'b0, 1'b0, 2'd0, 1'b1, 8'd125, TRW, FBW, TA, TB, OF, 20'sd175, 1'b0},
    '{4'd8, 1'b0, 1'b0, 2'd0, 1'b1, 8'd126, TRW, FBW, TA, TB, OF, 20'sd0,   1'b1},
    '{4'd8, 1'b1, 1'b0, 2'd0, 1'b1, 8'd74,  TRW, FBW, TA, TB, OF, 20'sd0,   1'b1},
    '{4'd8, 1'b1, 1'b0, 2'd0, 1'b1, 8'd75,  TRW, FBW, TA, TB, OF, 20'sd25,  1'b0},
    '{4'd8, 1'b1, 1'b0, 2'd0, 1'b1, 8'd175, TRW, FBW, TA, TB, OF, 20'sd125, 1'b0},
    '{4'd8, 1'b1, 1'b0, 2'd0, 1'b1, 8'd176, TRW, FBW, TA, TB, OF, 20'sd0,   1'b1},
    // R9 zero divisor
    '{4'd9, 1'b0, 1'b0, 2'd3, 1'b0, 8'd40,  TRW, FBW, TA, TA, OF, 20'sd0,   1'b1},
    '{4'd9, 1'b1, 1'b0, 2'd3, 1'b0, 8'd60,  16'h3232, FBW, TA, TB, OF, 20'sd0, 1'b1},
    '{4'd9, 1'b0, 1'b0, 2'd1, 1'b0, 8'd40,  TRW, FBW, TA, TA, OF, 20'sd65,  1'b0}
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic                 to_temp = 1'b0;
  logic                 hw_pass = 1'b0;
  logic [1:0]           cal_mode = 2'd0;
  logic                 legacy_chk = 1'b0;
  logic [VW-1:0]        din = '0;
  logic [TW-1:0]        trim_word = TRW;
  logic [TW-1:0]        fuse_word = FBW;
  logic [VW-1:0]        trim_min = 8'd40;
  logic [VW-1:0]        trim_max = 8'd120;
  logic [VW-1:0]        ref_t1 = TA;
  logic [VW-1:0]        ref_t2 = TB;
  logic signed [VW-1:0] def_ofs = 8'sd50;
  logic                 out_valid;
  logic signed [IW-1:0] out_value;
  logic                 out_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  thermo_code_conv u_thermo_code_conv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .to_temp(to_temp),
    .hw_pass(hw_pass), .cal_mode(cal_mode), .legacy_chk(legacy_chk),
    .din(din), .trim_word(trim_word), .fuse_word(fuse_word),
    .trim_min(trim_min), .trim_max(trim_max), .ref_t1(ref_t1),
    .ref_t2(ref_t2), .def_ofs(def_ofs), .out_valid(out_valid),
    .out_value(out_value), .out_err(out_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    to_temp    = v.dir;
    hw_pass    = v.hw;
    cal_mode   = v.mode;
    legacy_chk = v.leg;
    din        = v.din;
    trim_word  = v.trim;
    fuse_word  = v.fuse;
    ref_t1     = v.t1;
    ref_t2     = v.t2;
    def_ofs    = $signed(v.ofs);
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid   = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    check(out_valid == 1'b0, "R12", "valid in reset", int'(out_valid), 0);
    check(out_value == '0,   "R12", "value in reset", int'(out_value), 0);
    check(out_err == 1'b0,   "R12", "err in reset",   int'(out_err), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check(out_valid == 1'b1, $sformatf("R%0d", VEC[i].tag),
            $sformatf("vec %0d valid", i), int'(out_valid), 1);
      check($signed(out_value) == $signed(VEC[i].eval), $sformatf("R%0d", VEC[i].tag),
            $sformatf("vec %0d value", i), int'($signed(out_value)), int'($signed(VEC[i].eval)));
      check(out_err == VEC[i].eerr, $sformatf("R%0d", VEC[i].tag),
            $sformatf("vec %0d err", i), int'(out_err), int'(VEC[i].eerr));
    end

    // R11 hold without strobe: result of last vector (65) stays
    din      = 8'd99;
    cal_mode = 2'd0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "valid drops", int'(out_valid), 0);
    check($signed(out_value) == 65, "R11", "value held", int'($signed(out_value)), 65);
    check(out_err == 1'b0, "R11", "err held", int'(out_err), 0);

    // R11 error flag held too
    apply(VEC[25]);
    din = 8'd50;
    @(negedge clk);
    check(out_err == 1'b1, "R11", "err held high", int'(out_err), 1);
    check(out_valid == 1'b0, "R11", "valid low after hold", int'(out_valid), 0);

    // R12 reset mid-run clears a nonzero result
    apply(VEC[3]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_value == '0, "R12", "value after reset", int'(out_value), 0);
    check(out_valid == 1'b0, "R12", "valid after reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule